// File: doc/BRIEF.md
# Speculative Load Alias Detector

This block is a small associative table that lets a scheduler move a load above an older store, or replace a repeated load with a register copy. A protected load stores its start address and access size as a byte region. A checked store compares its own byte range with every valid region. The block raises a fault when any of those ranges overlap, so the software can fall back to in-order execution.

The table is emptied in one cycle when the speculative sequence commits or rolls back. When the table has no free entry, a further protected load cannot be recorded. In that case the block sets a sticky overflow flag, and every checked store faults until the next clear. This is the safe choice.

Top module: `alias_guard`

## Requirements
- R1: After reset the table is empty, and `full`, `ovf` and `fault` are all 0.
- R2: A protect request with `prot_vld`=1 stores its region in the lowest-numbered free entry. `full` is 1 exactly when all ENTRIES (default 8) entries hold regions.
- R3: A protect request while `full` is 1 stores nothing and sets `ovf`. While `ovf` is 1, every checked store faults, and `fault_idx` reads 0 when no region overlaps.
- R4: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. A checked store faults when its range [addr, addr+bytes) overlaps any valid region's range. Address sums do not wrap.
- R5: A checked store whose range only touches or misses every region, and `ovf` is 0, gives no fault.
- R6: `fault` is a one-cycle pulse in the cycle after the clock edge where `chk_vld` was sampled.
- R7: `fault_idx`, which is valid with `fault`, gives the lowest-numbered overlapping entry.
- R8: `clr` invalidates all entries and clears `ovf` at one edge. A protect request in the same cycle as `clr` is dropped. A store checked in that cycle is still compared with the table as it was before the clear.
- R9: A cycle with `chk_vld`=0 never causes a fault, whatever is on the store address. Such a cycle leaves the table unchanged.
- R10: When a protect request and a checked store arrive in the same cycle, the store is compared with the table before the new region is added.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_vld | input | 1 | Protected load request |
| prot_addr | input | AW | Start address of the protected load |
| prot_size | input | 2 | Size code of the protected load |
| chk_vld | input | 1 | Checked store request |
| chk_addr | input | AW | Start address of the checked store |
| chk_size | input | 2 | Size code of the checked store |
| clr | input | 1 | Commit/rollback clear |
| full | output | 1 | All entries valid |
| ovf | output | 1 | Sticky overflow flag |
| fault | output | 1 | Alias fault pulse |
| fault_idx | output | IW | Lowest overlapping entry index |

## Verification
The hardest states to reach are the ones at the edge of capacity. One is a checked store that arrives when the table is full, or in the same cycle as the ninth protect request. The other is a store whose range is exactly next to a region, or overlaps it only because of an 8-byte size, or lies at the top of the address space. The stimulus fills the table with regions placed at chosen byte offsets. It then sends stores one byte inside and one byte outside each boundary. It issues the overflow-causing protect together with a store, and a clear together with both a protect and a store. A behavioural model of the table is compared with the outputs on every clock.

// File: rtl/alias_guard.sv
module alias_guard #(
  parameter int ENTRIES = 8,
  parameter int AW = 32,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_vld,
  input  logic [AW-1:0] prot_addr,
  input  logic [1:0]    prot_size,
  input  logic          chk_vld,
  input  logic [AW-1:0] chk_addr,
  input  logic [1:0]    chk_size,
  input  logic          clr,
  output logic          full,
  output logic          ovf,
  output logic          fault,
  output logic [IW-1:0] fault_idx
);
  localparam logic [AW:0] ONE = {{AW{1'b0}}, 1'b1};

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] hit;
  logic [AW-1:0]      base [ENTRIES];
  logic [1:0]         sz   [ENTRIES];
  logic [IW-1:0]      hit_idx, free_idx;

  wire [AW:0] chk_lo = {1'b0, chk_addr};
  wire [AW:0] chk_hi = chk_lo + (ONE << chk_size);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    wire [AW:0] lo = {1'b0, base[i]};
    wire [AW:0] hi = lo + (ONE << sz[i]);
    assign hit[i] = vld[i] && (lo < chk_hi) && (chk_lo < hi);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i])  hit_idx  = IW'(i);
      if (!vld[i]) free_idx = IW'(i);
    end
  end

  assign full = &vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      ovf       <= 1'b0;
      fault     <= 1'b0;
      fault_idx <= '0;
    end else begin
      fault <= chk_vld && ((|hit) || ovf);
      if (chk_vld) fault_idx <= hit_idx;
      if (clr) begin
        vld <= '0;
        ovf <= 1'b0;
      end else if (prot_vld) begin
        if (full) ovf <= 1'b1;
        else      vld[free_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (prot_vld && !clr && !full) begin
      base[free_idx] <= prot_addr;
      sz[free_idx]   <= prot_size;
    end
  end
endmodule

// File: rtl/alias_guard_chk.sv
module alias_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic prot_vld,
  input logic chk_vld,
  input logic clr,
  input logic full,
  input logic ovf,
  input logic fault
);
  logic chk_d;
  always_ff @(posedge clk) chk_d <= rst_n && chk_vld;

  p_fault_after_check_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> chk_d);
  p_no_check_no_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_vld |=> !fault);
  p_ovf_forces_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld && ovf) |=> fault);
  p_ovf_needs_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> full);
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!full && !ovf));
  p_full_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_vld && !clr) |=> full == $past(full));
endmodule

bind alias_guard alias_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prot_vld(prot_vld), .chk_vld(chk_vld),
  .clr(clr), .full(full), .ovf(ovf), .fault(fault)
);

// File: tb/sim_alias_guard.sv
`timescale 1ns/1ps
module sim_alias_guard;
  localparam int N = 8;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic prot_vld = 0, chk_vld = 0, clr = 0;
  logic [AW-1:0] prot_addr = 0, chk_addr = 0;
  logic [1:0] prot_size = 0, chk_size = 0;
  logic full, ovf, fault;
  logic [2:0] fault_idx;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  alias_guard #(.ENTRIES(N), .AW(AW)) u0 (
    .clk, .rst_n, .prot_vld, .prot_addr, .prot_size,
    .chk_vld, .chk_addr, .chk_size, .clr,
    .full, .ovf, .fault, .fault_idx);

  bit m_v[N];
  longint m_a[N];
  int m_b[N];
  bit m_ovf, m_fault;
  int m_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_ovf = 0; m_fault = 0; m_idx = 0;
    end else begin
      bit f, hitany; int first; int cnt;
      longint sa; int sb;
      sa = chk_addr; sb = 1 << chk_size;
      hitany = 0; first = 0;
      for (int i = N - 1; i >= 0; i--)
        if (m_v[i] && m_a[i] < sa + sb && sa < m_a[i] + m_b[i]) begin
          hitany = 1; first = i;
        end
      f = chk_vld && (hitany || m_ovf);
      m_fault = f;
      if (chk_vld) m_idx = first;
      cnt = 0;
      foreach (m_v[i]) cnt += m_v[i];
      if (clr) begin
        foreach (m_v[i]) m_v[i] = 0;
        m_ovf = 0;
      end else if (prot_vld) begin
        if (cnt == N) m_ovf = 1;
        else begin
          for (int i = 0; i < N; i++)
            if (!m_v[i]) begin
              m_v[i] = 1; m_a[i] = prot_addr; m_b[i] = 1 << prot_size;
              break;
            end
        end
      end
    end
  end

  task automatic cmp(string tag);
    int cnt; cnt = 0;
    foreach (m_v[i]) cnt += m_v[i];
    checks++;
    if (fault !== m_fault || full !== (cnt == N) || ovf !== m_ovf ||
        (m_fault && fault_idx !== 3'(m_idx))) begin
      failures++;
      $display("FAIL %s: fault=%0b full=%0b ovf=%0b idx=%0d expected fault=%0b full=%0b ovf=%0b idx=%0d",
               tag, fault, full, ovf, fault_idx, m_fault, cnt == N, m_ovf, m_idx);
    end
  endtask

  task automatic step(string tag, bit p, longint pa, int ps, bit c, longint ca, int cs, bit cl);
    prot_vld = p; prot_addr = AW'(pa); prot_size = 2'(ps);
    chk_vld = c; chk_addr = AW'(ca); chk_size = 2'(cs); clr = cl;
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic expect_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_bit("R1 fault", fault, 1'b0);
    expect_bit("R1 full", full, 1'b0);
    expect_bit("R1 ovf", ovf, 1'b0);
    step("R1 empty check", 0, 0, 0, 1, 'h100, 3, 0);
    step("R6 idle", 0, 0, 0, 0, 0, 0, 0);
    // R2 fill with regions at spaced addresses
    step("R2 ins", 1, 'h100, 2, 0, 0, 0, 0);
    step("R2 ins", 1, 'h200, 3, 0, 0, 0, 0);
    step("R2 ins", 1, 'h300, 1, 0, 0, 0, 0);
    step("R2 ins", 1, 'h400, 0, 0, 0, 0, 0);
    // R4/R5 boundaries
    step("R5 adjacent after", 0, 0, 0, 1, 'h104, 0, 0);
    step("R4 last byte", 0, 0, 0, 1, 'h103, 0, 0);
    step("R6 pulse ends", 0, 0, 0, 0, 0, 0, 0);
    step("R5 adjacent before", 0, 0, 0, 1, 'h0FC, 2, 0);
    step("R4 straddle into", 0, 0, 0, 1, 'h0FF, 1, 0);
    step("R4 eight byte tail", 0, 0, 0, 1, 'h207, 0, 0);
    step("R5 past eight", 0, 0, 0, 1, 'h208, 3, 0);
    step("R4 half word", 0, 0, 0, 1, 'h301, 0, 0);
    step("R5 past half", 0, 0, 0, 1, 'h302, 1, 0);
    step("R9 unchecked store", 0, 0, 0, 0, 'h100, 3, 0);
    // R7 lowest index
    step("R7 ins dup", 1, 'h102, 1, 0, 0, 0, 0);
    step("R7 lowest", 0, 0, 0, 1, 'h102, 0, 0);
    step("R7 only high", 1, 'h500, 3, 0, 0, 0, 0);
    step("R7 idx5", 0, 0, 0, 1, 'h507, 0, 0);
    // R10 same cycle protect + check
    step("R10 not yet seen", 1, 'h600, 2, 1, 'h600, 0, 0);
    step("R10 now seen", 0, 0, 0, 1, 'h600, 0, 0);
    // top of address space
    step("R2 ins top", 1, 'hFFFFFFFC, 3, 0, 0, 0, 0);
    expect_bit("R2 full at eight", full, 1'b1);
    step("R4 top no wrap", 0, 0, 0, 1, 'hFFFFFFFF, 3, 0);
    step("R5 low addr no wrap", 0, 0, 0, 1, 'h0, 1, 0);
    // R3 overflow together with a miss check
    step("R3 overflow protect", 1, 'h900, 0, 1, 'h800, 0, 0);
    expect_bit("R3 ovf set", ovf, 1'b1);
    step("R3 miss faults", 0, 0, 0, 1, 'h900, 0, 0);
    step("R3 idx zero", 0, 0, 0, 1, 'hA00, 2, 0);
    step("R9 idle under ovf", 0, 0, 0, 0, 'h100, 0, 0);
    // R8 clear with protect and check
    step("R8 clear", 1, 'h100, 0, 1, 'h100, 0, 1);
    expect_bit("R8 ovf cleared", ovf, 1'b0);
    expect_bit("R8 full cleared", full, 1'b0);
    step("R8 dropped protect", 0, 0, 0, 1, 'h100, 0, 0);
    step("R2 reuse slot0", 1, 'h40, 0, 0, 0, 0, 0);
    step("R2 slot0 hit", 0, 0, 0, 1, 'h40, 0, 0);
    // back-to-back checks
    step("R6 b2b a", 0, 0, 0, 1, 'h40, 0, 0);
    step("R6 b2b b", 0, 0, 0, 1, 'h41, 0, 0);
    step("R6 b2b c", 0, 0, 0, 1, 'h40, 0, 0);
    step("R6 tail", 0, 0, 0, 0, 0, 0, 0);
    // sweep of sizes against one region
    for (int s = 0; s < 4; s++)
      for (int off = -9; off < 10; off++)
        step("R4 sweep", 0, 0, 0, 1, 'h40 + off, s, 0);
    step("R8 clear idle", 0, 0, 0, 0, 0, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule